// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block buffers received characters for a serial receiver. A deserializer offers bytes through a valid/ready style push port; the block accepts a byte only while the receiver is enabled and there is room. A line-break event is also accepted. It stores a zero character and raises a sticky break-change flag, and it is still taken when the queue is already full: the newest stored character is then replaced.

The host side pops the oldest character when it reads the receive data register. Every remaining character moves one place toward the head. The popped value is held on the read-data output until the next successful pop. The block derives two status bits from its occupancy: a receive-ready bit (at least one character stored) and a queue-full bit. A receiver-reset strobe discards all stored characters.

Top module: `rx_hold_queue`

## Requirements
- R1: The queue holds at most DEPTH (default 4) characters. `rx_ready` is 1 exactly when at least one character is stored. All status outputs reflect the state after each clock edge.
- R2: `push_ready` equals `rx_enable` AND NOT `q_full` AND NOT `brk_event`. A byte is stored at the edge where `push_valid` and `push_ready` are both 1.
- R3: `q_full` is 1 exactly when DEPTH characters are stored.
- R4: A `brk_event` cycle appends the value 0x00 and sets `brk_flag` from the next cycle on. In that cycle the data on `push_data` is not stored.
- R5: A `brk_event` while the queue holds DEPTH characters and no pop is applied overwrites the newest character with 0x00. The count stays at DEPTH.
- R6: A `pop` on a non-empty queue places the oldest character on `rd_data` from the next cycle and moves the remaining ones toward the head, so characters leave in arrival order.
- R7: A pop and a push (data or break) in the same cycle apply the pop first and then the push. A full queue that is popped in the same cycle as a break therefore keeps the break character as a new entry instead of overwriting.
- R8: A `pop` on an empty queue leaves `rd_data` unchanged and the count at zero. `rd_data` is 0x00 after reset.
- R9: `rx_reset` empties the queue in one cycle. It takes priority over a same-cycle pop, data push or break character, and `rd_data` keeps its value.
- R10: `brk_ack` clears `brk_flag`. A same-cycle `brk_event` wins and the flag stays set. `rx_reset` does not touch the flag.
- R11: While `rst_n` is low at a clock edge, the queue empties, `rd_data` becomes 0x00 and `brk_flag` clears.
- R12: A `push_valid` while `push_ready` is 0 (receiver disabled or queue full) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enabled; gates data pushes |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | DW | Offered byte |
| push_ready | output | 1 | Queue can take a data byte this cycle |
| brk_event | input | 1 | Line break detected; inserts 0x00 |
| brk_ack | input | 1 | Clears the break-change flag |
| pop | input | 1 | Host read of the receive data register |
| rx_reset | input | 1 | Receiver reset strobe; empties the queue |
| rd_data | output | DW | Last popped character |
| rx_ready | output | 1 | At least one character stored |
| q_full | output | 1 | DEPTH characters stored |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
Directed sequences fill the queue to DEPTH and drain it again. Ordered traffic tells correct head shifting apart from any reordering, and pushes into a full queue or a disabled receiver show that blocked bytes are truly dropped. Breaks are injected on an empty, a partly filled and a full queue, and once together with a pop. Comparing those cases separates append, overwrite-of-newest and pop-then-append. A long stretch of random push, pop, break, acknowledge and reset traffic then checks all status outputs against a queue model on every clock, which exposes collisions the directed cases miss.

// File: rtl/rxq_pkg.sv
// Package: shared defaults and types for the receive holding queue.
// Assumes byte-wide characters unless the top overrides DW.
package rxq_pkg;
    localparam int RXQ_DW    = 8;
    localparam int RXQ_DEPTH = 4;

    // Source of the character written this cycle.
    typedef enum logic {
        WSRC_DATA  = 1'b0,
        WSRC_BREAK = 1'b1
    } rxq_wsrc_e;
endpackage

// File: rtl/rxq_ctrl.sv
// Module: rxq_ctrl
// Tracks occupancy and the break-change flag. It decides per cycle whether
// the queue shifts (pop), where a new character lands and whether it comes
// from the data port or is a break zero.
// Assumes: rx_reset dominates; pop is applied before push; a break on a
// full queue without a pop overwrites the newest slot.
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = RXQ_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          push_valid,
    input  logic          brk_event,
    input  logic          brk_ack,
    input  logic          pop,
    input  logic          rx_reset,
    output logic          push_ready,
    output logic          do_shift,
    output logic          wr_en,
    output rxq_wsrc_e     wr_src,
    output logic [IW-1:0] wr_idx,
    output logic          rx_ready,
    output logic          q_full,
    output logic          brk_flag
);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_after_pop;
    logic [CW-1:0] cnt_d;
    logic          take_data;

    // Status decoded from occupancy.
    assign rx_ready   = (cnt_q != '0);
    assign q_full     = (cnt_q == CNT_MAX);
    assign push_ready = rx_enable && !q_full && !brk_event;
    assign take_data  = push_valid && push_ready;

    // Next occupancy and write slot: pop first, then append or overwrite.
    always_comb begin
        do_shift      = 1'b0;
        wr_en         = 1'b0;
        wr_src        = brk_event ? WSRC_BREAK : WSRC_DATA;
        wr_idx        = '0;
        cnt_after_pop = cnt_q;
        cnt_d         = cnt_q;
        if (rx_reset) begin
            cnt_d = '0;
        end else begin
            if (pop && rx_ready) begin
                do_shift      = 1'b1;
                cnt_after_pop = cnt_q - CNT_ONE;
            end
            cnt_d = cnt_after_pop;
            if (brk_event || take_data) begin
                wr_en = 1'b1;
                if (cnt_after_pop == CNT_MAX) begin
                    wr_idx = IW'(DEPTH - 1);
                end else begin
                    wr_idx = cnt_after_pop[IW-1:0];
                    cnt_d  = cnt_after_pop + CNT_ONE;
                end
            end
        end
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Sticky break-change flag; a new break outranks the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         brk_flag <= 1'b0;
        else if (brk_event) brk_flag <= 1'b1;
        else if (brk_ack)   brk_flag <= 1'b0;
    end

    // R1: occupancy never exceeds the depth
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    // R2: no data acceptance while full
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !push_ready);
    // R4: break raises the flag
    p_brk_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_event |=> brk_flag);
    // R5: break on full without pop keeps the queue full
    p_brk_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && brk_event && !pop && !rx_reset) |=> q_full);
    // R9: receiver reset empties the queue
    p_rxreset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> !rx_ready);
    // R10: receiver reset leaves the flag alone
    p_flag_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_reset && !brk_event && !brk_ack) |=> $stable(brk_flag));
endmodule

// File: rtl/rxq_store.sv
// Module: rxq_store
// Shifting character storage plus the read-data register. A shift moves
// every slot one toward the head (slot 0); the top slot fills with zero.
// The write slot index is relative to the post-shift layout.
// Assumes: do_shift is only asserted when slot 0 holds a valid character.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DW    = RXQ_DW,
    parameter int DEPTH = RXQ_DEPTH,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_reset,
    input  logic          do_shift,
    input  logic          wr_en,
    input  rxq_wsrc_e     wr_src,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slot_q [DEPTH];
    logic [DW-1:0] wr_val;

    // Break characters are stored as zero.
    assign wr_val = (wr_src == WSRC_BREAK) ? '0 : push_data;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] above;
        if (i == DEPTH - 1) begin : g_top
            assign above = '0;
        end else begin : g_mid
            assign above = slot_q[i+1];
        end

        // One slot: clear, shift down, then optional write.
        always_ff @(posedge clk) begin
            if (!rst_n || rx_reset) begin
                slot_q[i] <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                slot_q[i] <= wr_val;
            end else if (do_shift) begin
                slot_q[i] <= above;
            end
        end
    end

    // Read-data holder: captures the head on each successful pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rd_data <= '0;
        else if (do_shift && !rx_reset) rd_data <= slot_q[0];
    end

    // R8: without a shift the read data holds
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !do_shift |=> $stable(rd_data));
endmodule

// File: rtl/rx_hold_queue.sv
// Module: rx_hold_queue (top)
// Receive holding queue with break insertion. Joins the occupancy/flag
// controller and the shifting storage.
// Assumes: a single clock, synchronous active-low reset, and a pop strobe
// of one cycle per host read.
module rx_hold_queue
    import rxq_pkg::*;
#(
    parameter int DW    = RXQ_DW,
    parameter int DEPTH = RXQ_DEPTH,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          brk_event,
    input  logic          brk_ack,
    input  logic          pop,
    input  logic          rx_reset,
    output logic [DW-1:0] rd_data,
    output logic          rx_ready,
    output logic          q_full,
    output logic          brk_flag
);
    logic          do_shift;
    logic          wr_en;
    rxq_wsrc_e     wr_src;
    logic [IW-1:0] wr_idx;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .push_valid (push_valid),
        .brk_event  (brk_event),
        .brk_ack    (brk_ack),
        .pop        (pop),
        .rx_reset   (rx_reset),
        .push_ready (push_ready),
        .do_shift   (do_shift),
        .wr_en      (wr_en),
        .wr_src     (wr_src),
        .wr_idx     (wr_idx),
        .rx_ready   (rx_ready),
        .q_full     (q_full),
        .brk_flag   (brk_flag)
    );

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_reset  (rx_reset),
        .do_shift  (do_shift),
        .wr_en     (wr_en),
        .wr_src    (wr_src),
        .wr_idx    (wr_idx),
        .push_data (push_data),
        .rd_data   (rd_data)
    );

    // R6: an empty queue never shifts
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !wr_en) |=> !rx_ready);
    // R3: full implies ready
    p_full_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> rx_ready);
endmodule

// File: tb/tb_rx_hold_queue.sv
// Bench: behavioural queue model, compared with the design after every edge.
module tb_rx_hold_queue;
    localparam int DW    = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rx_enable, push_valid, brk_event, brk_ack, pop, rx_reset;
    logic [DW-1:0] push_data;
    logic          push_ready, rx_ready, q_full, brk_flag;
    logic [DW-1:0] rd_data;

    int vectors  = 0;
    int mismatch = 0;
    bit finished = 0;
    string scen  = "R11";

    logic [DW-1:0] mq[$];
    logic [DW-1:0] m_rd;
    bit            m_flag;

    always #5 clk = ~clk;

    rx_hold_queue #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .push_valid(push_valid), .push_data(push_data),
        .push_ready(push_ready), .brk_event(brk_event), .brk_ack(brk_ack),
        .pop(pop), .rx_reset(rx_reset), .rd_data(rd_data),
        .rx_ready(rx_ready), .q_full(q_full), .brk_flag(brk_flag)
    );

    function automatic bit exp_ready();
        return rx_enable && (mq.size() < DEPTH) && !brk_event;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            mismatch++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, scen, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 rx_ready",   DW'(rx_ready),   DW'(mq.size() != 0));
        chk("R3 q_full",     DW'(q_full),     DW'(mq.size() == DEPTH));
        chk("R2 push_ready", DW'(push_ready), DW'(exp_ready()));
        chk("R6 rd_data",    rd_data,         m_rd);
        chk("R4 brk_flag",   DW'(brk_flag),   DW'(m_flag));
    endtask

    // One clock: apply inputs, update model at the edge, compare after it.
    task automatic cyc(bit en, bit pv, logic [DW-1:0] d, bit brk, bit ack, bit pp, bit clr);
        bit pr;
        rx_enable = en; push_valid = pv; push_data = d;
        brk_event = brk; brk_ack = ack; pop = pp; rx_reset = clr;
        #1;
        pr = exp_ready();
        chk("R2 push_ready", DW'(push_ready), DW'(pr));
        @(posedge clk);
        if (!rst_n) begin
            mq.delete(); m_rd = '0; m_flag = 0;
        end else begin
            if (clr) mq.delete();
            else begin
                if (pp && mq.size() > 0) m_rd = mq.pop_front();
                if (brk) begin
                    if (mq.size() == DEPTH) mq[DEPTH-1] = '0;
                    else mq.push_back('0);
                end else if (pv && pr) mq.push_back(d);
            end
            if (brk) m_flag = 1;
            else if (ack) m_flag = 0;
        end
        #2;
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1, 0, '0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatch++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, mismatch);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        m_rd = '0; m_flag = 0;
        // R11: reset state
        cyc(0, 0, '0, 0, 0, 0, 0);
        cyc(0, 0, '0, 0, 0, 0, 0);
        rst_n = 1;
        idle(1);
        scen = "R8 empty pop after reset";
        cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R3 fill";
        for (int i = 0; i < DEPTH; i++) cyc(1, 1, DW'(8'hA0 + i), 0, 0, 0, 0);
        scen = "R12 push while full";
        cyc(1, 1, 8'h55, 0, 0, 0, 0);
        scen = "R6 drain in order";
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R8 empty pop keeps rd_data";
        cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R12 receiver disabled";
        cyc(0, 1, 8'h77, 0, 0, 0, 0);
        cyc(0, 0, '0, 0, 0, 1, 0);
        scen = "R4 break on empty, data same cycle";
        cyc(1, 1, 8'h99, 1, 0, 0, 0);
        cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R10 ack against break";
        cyc(1, 0, '0, 1, 1, 0, 0);
        cyc(1, 0, '0, 0, 1, 0, 0);
        cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R5 break on full overwrites newest";
        for (int i = 0; i < DEPTH; i++) cyc(1, 1, DW'(8'hB0 + i), 0, 0, 0, 0);
        cyc(1, 0, '0, 1, 0, 0, 0);
        scen = "R7 break with pop on full appends";
        cyc(1, 0, '0, 1, 0, 1, 0);
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R7 pop and push same cycle";
        cyc(1, 1, 8'hC1, 0, 0, 0, 0);
        cyc(1, 1, 8'hC2, 0, 0, 1, 0);
        cyc(1, 1, 8'hC3, 0, 0, 1, 0);
        cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R9 receiver reset beats pop and push";
        cyc(1, 1, 8'hD1, 0, 0, 0, 0);
        cyc(1, 1, 8'hD2, 0, 0, 0, 0);
        cyc(1, 1, 8'hD3, 1, 0, 1, 1);
        cyc(1, 0, '0, 0, 0, 1, 0);
        scen = "R1 random traffic";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            cyc(r > 5, $urandom_range(0, 1) == 1, DW'($urandom),
                r < 4, r > 90, $urandom_range(0, 2) == 0, r == 50);
        end
        scen = "R11 reset mid-stream";
        cyc(1, 1, 8'hE1, 1, 0, 0, 0);
        rst_n = 0;
        cyc(1, 1, 8'hE2, 0, 0, 0, 0);
        rst_n = 1;
        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, mismatch);
        $finish;
    end
endmodule